// File: doc/BRIEF.md
# Reset Release and Clock Start-up Sequencer

This block keeps a processor core in reset after a power-on, a brown-out, or a software or external reset. It releases the core only after a programmable supply settling time. It then waits until the selected clock source can be trusted, raises a clock-ready flag, emits a one-cycle boot strobe that carries the boot vector, and can later enable a clock-failure monitor. Each analog wait is modelled as a down-counter on the reference clock, with its length set by a parameter. Crystal warm-up is measured in oscillator ticks, which arrive on a separate input.

The reset causes fall into two classes. Power-on and brown-out are cold causes, and a cold cause loads the configured clock source into the active source register. Software and external resets are warm causes, and a warm cause leaves the active source unchanged. The clock source decides which wait stages run. Crystal sources add a tick-counted warm-up stage. Sources that use the PLL add a lock wait. The slow low-power RC source uses a longer settling wait than the other sources.

Top module: `rst_clk_seq`

## Requirements
- R1: A cold cause (`por_p` or `bor_p`) loads `cfg_src` into `clk_src` on the next edge. When a cold cause and a warm cause (`sw_rst_p`, `ext_rst_p`) arrive together, the cold cause wins. A warm cause alone, or a change of `cfg_src` with no cold cause, leaves `clk_src` unchanged.
- R2: `seq_state` moves only forward through the encoding hold=0, power-up wait=1, settle=2, crystal count=3, PLL lock=4, monitor delay=5, run=6. Stages that do not apply are skipped. Hold lasts exactly one cycle.
- R3: `core_rst` is high in hold and in the power-up wait, and falls when the wait ends. The wait lasts (`pup_sel`+1)*PUP_UNIT cycles, which is 16 cycles per step by default.
- R4: The settle stage lasts SETTLE_SLOW (64) cycles for source code 5 (slow RC) and SETTLE_FAST (4) cycles for every other code. The source codes are: 0 fast RC, 1 fast RC with PLL, 2 primary, 3 primary with PLL, 4 secondary crystal, 5 slow RC, 6 fast RC divided by 16, 7 fast RC with a programmable divider.
- R5: The crystal count stage runs for code 4, and for codes 2 and 3 when `prim_xtal`=1. It ends on the XTAL_TICKS-th (1024th) `osc_tick` pulse, and it does not advance while `osc_tick` is low.
- R6: A PLL lock stage of LOCK_CYC (96) cycles follows the settle stage and any crystal count stage, but only for codes 1 and 3.
- R7: `clk_rdy` is high in the monitor delay stage and in run. `boot_stb` is high for exactly the first clock-ready cycle, and `boot_addr` then carries BOOT_VEC (0). At all other times `boot_addr` is 0.
- R8: With `mon_cfg`=1, a monitor delay of MON_CYC (8) cycles follows clock-ready, and after it `mon_en` rises. With `mon_cfg`=0 there is no monitor delay stage and `mon_en` stays low.
- R9: Any reset cause, in any stage, returns the sequencer to hold on the next edge. This reasserts `core_rst` and clears `clk_rdy` and `mon_en`.
- R10: While `rst_n` is low (synchronous, active-low), the sequencer is held in hold and `clk_src` follows `cfg_src`, as it would after a power-on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| por_p | input | 1 | Power-on cause pulse (cold) |
| bor_p | input | 1 | Brown-out cause pulse (cold) |
| sw_rst_p | input | 1 | Software reset pulse (warm) |
| ext_rst_p | input | 1 | External reset pulse (warm) |
| cfg_src | input | 3 | Configured clock source code |
| prim_xtal | input | 1 | Primary source is a crystal (1) or an external clock (0) |
| mon_cfg | input | 1 | Clock monitor configured on |
| pup_sel | input | PUP_W | Power-up wait length selector |
| osc_tick | input | 1 | One pulse per oscillator period, synchronised to clk |
| core_rst | output | 1 | System reset to the core, active high |
| clk_src | output | 3 | Active clock source code |
| clk_rdy | output | 1 | Clock ready |
| boot_stb | output | 1 | One-cycle start-of-execution strobe |
| boot_addr | output | ADDR_W | Boot vector while the strobe is high, 0 otherwise |
| mon_en | output | 1 | Clock monitor enable |
| seq_state | output | 3 | Current stage code |

## Verification
The assertions assume three things about the inputs. Each reset cause is a pulse. `cfg_src`, `prim_xtal`, `mon_cfg` and `pup_sel` are not changed in the middle of a sequence, except when the change is made to test that it is ignored. `osc_tick` is already synchronised to `clk`. The stimulus changes these settings only at a falling clock edge just before a cause pulse, or while the block is in run. It then checks that a later change of `cfg_src` leaves the active source alone. Cause pulses are kept one cycle wide. The only exception is a deliberate overlap of a cold cause and a warm cause in the same cycle, which exercises the rule that the cold cause wins.

// File: rtl/rst_seq_pkg.sv
// Package: shared stage and clock-source codes for the reset sequencer.
// Assumes: the stage order is encoded so that a later stage has a larger code.
package rst_seq_pkg;

    typedef enum logic [2:0] {
        ST_HOLD   = 3'd0,
        ST_PWRUP  = 3'd1,
        ST_SETTLE = 3'd2,
        ST_XCOUNT = 3'd3,
        ST_LOCK   = 3'd4,
        ST_MONDLY = 3'd5,
        ST_RUN    = 3'd6
    } seq_state_e;

    typedef enum logic [2:0] {
        SRC_RCF     = 3'd0,
        SRC_RCF_PLL = 3'd1,
        SRC_PRI     = 3'd2,
        SRC_PRI_PLL = 3'd3,
        SRC_XT2     = 3'd4,
        SRC_RCS     = 3'd5,
        SRC_RCF_D16 = 3'd6,
        SRC_RCF_DN  = 3'd7
    } clk_src_e;

    // Crystal warm-up counting applies to the secondary crystal and to a crystal primary.
    function automatic logic needs_xcount(input logic [2:0] src, input logic prim_xtal);
        return (src == SRC_XT2) ||
               (prim_xtal && ((src == SRC_PRI) || (src == SRC_PRI_PLL)));
    endfunction

    // A PLL lock wait applies to the two sources routed through the PLL.
    function automatic logic needs_lock(input logic [2:0] src);
        return (src == SRC_RCF_PLL) || (src == SRC_PRI_PLL);
    endfunction

endpackage

// File: rtl/rsq_cause_dec.sv
// Module: sorts reset causes into cold and warm, and holds the active clock source.
// Assumes: cause inputs are one-cycle pulses already synchronised to clk.
module rsq_cause_dec (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       por_p,
    input  logic       bor_p,
    input  logic       sw_rst_p,
    input  logic       ext_rst_p,
    input  logic [2:0] cfg_src,
    output logic       restart,
    output logic [2:0] clk_src
);
    logic cold;
    logic warm;
    logic [2:0] src_q;

    assign cold    = por_p | bor_p;
    assign warm    = sw_rst_p | ext_rst_p;
    assign restart = cold | warm;
    assign clk_src = src_q;

    // Active source: reloaded by reset or a cold cause, kept otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= cfg_src;
        end else if (cold) begin
            src_q <= cfg_src;
        end
    end
endmodule

// File: rtl/rsq_stage_plan.sv
// Module: picks the stage that follows the current one, from the source code and the configuration.
// Assumes: purely combinational; the caller decides when to take the step.
module rsq_stage_plan
    import rst_seq_pkg::*;
(
    input  seq_state_e st,
    input  logic [2:0] src,
    input  logic       prim_xtal,
    input  logic       mon_cfg,
    output seq_state_e nxt
);
    seq_state_e after_osc;

    // Stage entered once the oscillator waits are over.
    always_comb after_osc = mon_cfg ? ST_MONDLY : ST_RUN;

    // Successor stage, skipping stages that do not apply to this source.
    always_comb begin
        unique case (st)
            ST_HOLD:   nxt = ST_PWRUP;
            ST_PWRUP:  nxt = ST_SETTLE;
            ST_SETTLE: nxt = needs_xcount(src, prim_xtal) ? ST_XCOUNT :
                             needs_lock(src) ? ST_LOCK : after_osc;
            ST_XCOUNT: nxt = needs_lock(src) ? ST_LOCK : after_osc;
            ST_LOCK:   nxt = after_osc;
            ST_MONDLY: nxt = ST_RUN;
            default:   nxt = ST_RUN;
        endcase
    end
endmodule

// File: rtl/rsq_stage_timer.sv
// Module: the reference-clock down-counter and the oscillator-tick counter used by the timed stages.
// Assumes: load is high on the edge that enters a stage; a stage of N cycles loads N-1.
module rsq_stage_timer #(
    parameter int CW         = 7,
    parameter int XTAL_TICKS = 1024,
    localparam int TW        = $clog2(XTAL_TICKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          osc_tick,
    output logic          ref_done,
    output logic          tick_done
);
    localparam logic [TW-1:0] TICK_LAST = TW'(XTAL_TICKS - 1);

    logic [CW-1:0] cnt_q;
    logic [TW-1:0] tick_q;

    assign ref_done  = (cnt_q == '0);
    assign tick_done = osc_tick && (tick_q == TICK_LAST);

    // Reference-cycle countdown toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Oscillator tick count, cleared on stage entry and saturating at its last value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q <= '0;
        end else if (load) begin
            tick_q <= '0;
        end else if (osc_tick && (tick_q != TICK_LAST)) begin
            tick_q <= tick_q + 1'b1;
        end
    end
endmodule

// File: rtl/rst_clk_seq.sv
// Module: top of the reset-release and clock start-up sequencer.
// Assumes: configuration inputs are steady during a sequence; osc_tick is synchronised to clk.
module rst_clk_seq
    import rst_seq_pkg::*;
#(
    parameter int PUP_W       = 2,
    parameter int PUP_UNIT    = 16,
    parameter int SETTLE_FAST = 4,
    parameter int SETTLE_SLOW = 64,
    parameter int XTAL_TICKS  = 1024,
    parameter int LOCK_CYC    = 96,
    parameter int MON_CYC     = 8,
    parameter int ADDR_W      = 24,
    parameter logic [ADDR_W-1:0] BOOT_VEC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_p,
    input  logic              bor_p,
    input  logic              sw_rst_p,
    input  logic              ext_rst_p,
    input  logic [2:0]        cfg_src,
    input  logic              prim_xtal,
    input  logic              mon_cfg,
    input  logic [PUP_W-1:0]  pup_sel,
    input  logic              osc_tick,
    output logic              core_rst,
    output logic [2:0]        clk_src,
    output logic              clk_rdy,
    output logic              boot_stb,
    output logic [ADDR_W-1:0] boot_addr,
    output logic              mon_en,
    output logic [2:0]        seq_state
);
    localparam int PUP_MAX = (2 ** PUP_W) * PUP_UNIT;
    localparam int M1      = (PUP_MAX > SETTLE_SLOW) ? PUP_MAX : SETTLE_SLOW;
    localparam int M2      = (M1 > SETTLE_FAST) ? M1 : SETTLE_FAST;
    localparam int M3      = (M2 > LOCK_CYC) ? M2 : LOCK_CYC;
    localparam int MAXC    = (M3 > MON_CYC) ? M3 : MON_CYC;
    localparam int CW      = $clog2(MAXC);

    seq_state_e    st_q;
    seq_state_e    st_nxt;
    seq_state_e    plan_nxt;
    logic          restart;
    logic          ref_done;
    logic          tick_done;
    logic          stage_done;
    logic          adv;
    logic          rdy_now;
    logic          boot_q;
    logic [CW-1:0] load_val;

    rsq_cause_dec u_cause (
        .clk       (clk),
        .rst_n     (rst_n),
        .por_p     (por_p),
        .bor_p     (bor_p),
        .sw_rst_p  (sw_rst_p),
        .ext_rst_p (ext_rst_p),
        .cfg_src   (cfg_src),
        .restart   (restart),
        .clk_src   (clk_src)
    );

    rsq_stage_plan u_plan (
        .st        (st_q),
        .src       (clk_src),
        .prim_xtal (prim_xtal),
        .mon_cfg   (mon_cfg),
        .nxt       (plan_nxt)
    );

    rsq_stage_timer #(
        .CW         (CW),
        .XTAL_TICKS (XTAL_TICKS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (adv),
        .load_val  (load_val),
        .osc_tick  (osc_tick),
        .ref_done  (ref_done),
        .tick_done (tick_done)
    );

    // Stage completion: hold takes one cycle, crystal count uses ticks, run never completes.
    always_comb begin
        unique case (st_q)
            ST_HOLD:                                  stage_done = 1'b1;
            ST_PWRUP, ST_SETTLE, ST_LOCK, ST_MONDLY:  stage_done = ref_done;
            ST_XCOUNT:                                stage_done = tick_done;
            default:                                  stage_done = 1'b0;
        endcase
    end

    // Counter reload for the stage about to be entered.
    always_comb begin
        unique case (plan_nxt)
            ST_PWRUP:  load_val = CW'((int'(pup_sel) + 1) * PUP_UNIT - 1);
            ST_SETTLE: load_val = (clk_src == SRC_RCS) ? CW'(SETTLE_SLOW - 1)
                                                       : CW'(SETTLE_FAST - 1);
            ST_LOCK:   load_val = CW'(LOCK_CYC - 1);
            ST_MONDLY: load_val = CW'(MON_CYC - 1);
            default:   load_val = '0;
        endcase
    end

    assign adv     = stage_done && !restart;
    assign rdy_now = (st_q == ST_MONDLY) || (st_q == ST_RUN);

    // Next stage: a cause always wins, otherwise step when the stage is done.
    always_comb st_nxt = restart ? ST_HOLD : (adv ? plan_nxt : st_q);

    // Stage register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_HOLD;
        end else begin
            st_q <= st_nxt;
        end
    end

    // Boot strobe register: set on the step that first makes the clock ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boot_q <= 1'b0;
        end else begin
            boot_q <= adv && !rdy_now &&
                      ((plan_nxt == ST_MONDLY) || (plan_nxt == ST_RUN));
        end
    end

    assign core_rst  = (st_q == ST_HOLD) || (st_q == ST_PWRUP);
    assign clk_rdy   = rdy_now;
    assign boot_stb  = boot_q;
    assign boot_addr = boot_q ? BOOT_VEC : '0;
    assign mon_en    = (st_q == ST_RUN) && mon_cfg;
    assign seq_state = st_q;
endmodule

// File: rtl/rst_clk_seq_chk.sv
// Module: assertion checker for rst_clk_seq, attached by bind below.
// Assumes: cause inputs are pulses; configuration is steady within a sequence.
module rst_clk_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       por_p,
    input logic       bor_p,
    input logic       sw_rst_p,
    input logic       ext_rst_p,
    input logic [2:0] cfg_src,
    input logic       prim_xtal,
    input logic       mon_cfg,
    input logic       core_rst,
    input logic [2:0] clk_src,
    input logic       clk_rdy,
    input logic       boot_stb,
    input logic       mon_en,
    input logic [2:0] seq_state
);
    logic cold;
    logic any_cause;

    assign cold      = por_p || bor_p;
    assign any_cause = cold || sw_rst_p || ext_rst_p;

    AST_COLD_LOADS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        cold |=> clk_src == $past(cfg_src)); // R1
    AST_SRC_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !cold |=> $stable(clk_src)); // R1
    AST_STAGE_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        !any_cause |=> seq_state >= $past(seq_state)); // R2
    AST_RELEASE_POINT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_rst) |-> (seq_state == 3'd2) && ($past(seq_state) == 3'd1)); // R3
    AST_XCOUNT_ONLY_XTAL: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 3'd3) |-> (clk_src == 3'd4) ||
                                (prim_xtal && ((clk_src == 3'd2) || (clk_src == 3'd3)))); // R5
    AST_LOCK_ONLY_PLL: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 3'd4) |-> (clk_src == 3'd1) || (clk_src == 3'd3)); // R6
    AST_BOOT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        boot_stb |=> !boot_stb); // R7
    AST_BOOT_AT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        boot_stb |-> $rose(clk_rdy)); // R7
    AST_MON_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        mon_en |-> clk_rdy && mon_cfg); // R8
    AST_CAUSE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        any_cause |=> (seq_state == 3'd0) && core_rst && !clk_rdy && !mon_en); // R9
    AST_RESET_HOLD: assert property (@(posedge clk)
        !rst_n |=> (seq_state == 3'd0) && (clk_src == $past(cfg_src))); // R10
endmodule

bind rst_clk_seq rst_clk_seq_chk chk_i (.*);

// File: tb/rst_clk_seq_tb_top.sv
`timescale 1ns/100ps
// Bench: table-driven sequence checks, then directed tests for reset, restart and tick stalls.
module rst_clk_seq_tb_top;

    localparam int MON_CYC = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       por_p = 1'b0, bor_p = 1'b0, sw_rst_p = 1'b0, ext_rst_p = 1'b0;
    logic [2:0] cfg_src = 3'd3;
    logic       prim_xtal = 1'b0, mon_cfg = 1'b0, osc_tick = 1'b1;
    logic [1:0] pup_sel = 2'd0;
    logic       core_rst, clk_rdy, boot_stb, mon_en;
    logic [2:0] clk_src, seq_state;
    logic [23:0] boot_addr;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    rst_clk_seq dut_i (
        .clk(clk), .rst_n(rst_n), .por_p(por_p), .bor_p(bor_p),
        .sw_rst_p(sw_rst_p), .ext_rst_p(ext_rst_p), .cfg_src(cfg_src),
        .prim_xtal(prim_xtal), .mon_cfg(mon_cfg), .pup_sel(pup_sel),
        .osc_tick(osc_tick), .core_rst(core_rst), .clk_src(clk_src),
        .clk_rdy(clk_rdy), .boot_stb(boot_stb), .boot_addr(boot_addr),
        .mon_en(mon_en), .seq_state(seq_state)
    );

    typedef struct packed {
        logic [2:0]  src;
        logic        xtal;
        logic        mon;
        logic [1:0]  pup;
        logic [15:0] ecyc;
        logic [7:0]  rel;
        logic [6:0]  mask;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 1'b0, 1'b0, 2'd0, 16'd21,   8'd17, 7'h47},
        '{3'd1, 1'b0, 1'b1, 2'd1, 16'd133,  8'd33, 7'h77},
        '{3'd2, 1'b1, 1'b0, 2'd0, 16'd1045, 8'd17, 7'h4F},
        '{3'd2, 1'b0, 1'b0, 2'd3, 16'd69,   8'd65, 7'h47},
        '{3'd3, 1'b1, 1'b1, 2'd2, 16'd1173, 8'd49, 7'h7F},
        '{3'd3, 1'b0, 1'b0, 2'd0, 16'd117,  8'd17, 7'h57},
        '{3'd4, 1'b0, 1'b1, 2'd0, 16'd1045, 8'd17, 7'h6F},
        '{3'd5, 1'b0, 1'b0, 2'd0, 16'd81,   8'd17, 7'h47},
        '{3'd6, 1'b0, 1'b0, 2'd1, 16'd37,   8'd33, 7'h47},
        '{3'd7, 1'b0, 1'b1, 2'd0, 16'd21,   8'd17, 7'h67}
    };

    // Compare one value and record the result.
    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // Drive a one-cycle cause pulse: bit0 power-on, bit1 brown-out, bit2 software, bit3 external.
    task automatic pulse(input int kind);
        @(negedge clk);
        por_p = kind[0]; bor_p = kind[1]; sw_rst_p = kind[2]; ext_rst_p = kind[3];
        @(negedge clk);
        por_p = 1'b0; bor_p = 1'b0; sw_rst_p = 1'b0; ext_rst_p = 1'b0;
    endtask

    // Follow one sequence from hold to clock-ready (and monitor enable) and check it.
    task automatic observe(input logic mon, input int exp_e, input int exp_rel,
                           input logic [6:0] exp_mask, input logic [2:0] exp_src);
        int n = 0;
        int rel = -1;
        int m = 0;
        int extra_boot = 0;
        int early_boot = 0;
        logic [6:0] seen = '0;
        int mono = 1;
        logic [2:0] prev = seq_state;
        seen[seq_state] = 1'b1;
        if (!core_rst) rel = 0;
        while (!clk_rdy && n < 4000) begin
            if (boot_stb) early_boot++;
            @(negedge clk);
            n++;
            if (seq_state < prev) mono = 0;
            prev = seq_state;
            seen[seq_state] = 1'b1;
            if (!core_rst && rel < 0) rel = n;
        end
        chk("R4 R5 R6 cycles to clock-ready", n, exp_e);
        chk("R3 core reset release cycle", rel, exp_rel);
        chk("R7 boot strobe on first ready cycle", int'(boot_stb) + early_boot * 2, 1);
        chk("R7 boot vector", int'(boot_addr), 0);
        chk("R1 active source", int'(clk_src), int'(exp_src));
        if (mon) begin
            while (!mon_en && m < 100) begin
                @(negedge clk);
                m++;
                if (boot_stb) extra_boot++;
                if (seq_state < prev) mono = 0;
                prev = seq_state;
                seen[seq_state] = 1'b1;
            end
            chk("R8 monitor delay", m, MON_CYC);
        end else begin
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (mon_en) m++;
                if (boot_stb) extra_boot++;
                seen[seq_state] = 1'b1;
            end
            chk("R8 monitor stays off", m, 0);
        end
        chk("R7 single boot strobe", extra_boot, 0);
        chk("R2 forward order", mono, 1);
        chk("R2 stages visited", int'(seen), int'(exp_mask));
    endtask

    // Configure, fire a cause and check the resulting sequence.
    task automatic run_seq(input logic [2:0] src, input logic xtal, input logic mon,
                           input logic [1:0] pup, input int kind, input int exp_e,
                           input int exp_rel, input logic [6:0] exp_mask,
                           input logic [2:0] exp_src);
        @(negedge clk);
        cfg_src = src; prim_xtal = xtal; mon_cfg = mon; pup_sel = pup;
        pulse(kind);
        observe(mon, exp_e, exp_rel, exp_mask, exp_src);
    endtask

    initial begin
        int n;
        // R10: reset state with source code 3 configured.
        repeat (3) @(negedge clk);
        chk("R10 reset stage", int'(seq_state), 0);
        chk("R10 reset core_rst", int'(core_rst), 1);
        chk("R10 reset clk_rdy", int'(clk_rdy), 0);
        chk("R10 reset mon_en", int'(mon_en), 0);
        chk("R10 reset boot_stb", int'(boot_stb), 0);
        chk("R10 reset source", int'(clk_src), 3);
        rst_n = 1'b1;
        observe(1'b0, 117, 17, 7'h57, 3'd3);

        // Table: every source code under a cold power-on cause.
        for (int v = 0; v < NV; v++) begin
            run_seq(VECS[v].src, VECS[v].xtal, VECS[v].mon, VECS[v].pup, 1,
                    int'(VECS[v].ecyc), int'(VECS[v].rel), VECS[v].mask, VECS[v].src);
        end

        // R1 R4: warm reset keeps the slow RC source although the configuration changed.
        run_seq(3'd5, 1'b0, 1'b0, 2'd0, 1, 81, 17, 7'h47, 3'd5);
        @(negedge clk) cfg_src = 3'd0;
        repeat (5) @(negedge clk);
        chk("R1 config change ignored without cold cause", int'(clk_src), 5);
        pulse(4);
        observe(1'b0, 81, 17, 7'h47, 3'd5);

        // R1: brown-out is cold and loads the new source.
        run_seq(3'd0, 1'b0, 1'b0, 2'd0, 2, 21, 17, 7'h47, 3'd0);

        // R1: cold and warm together, the cold cause wins.
        run_seq(3'd6, 1'b0, 1'b0, 2'd0, 9, 21, 17, 7'h47, 3'd6);

        // R9: warm restart in the middle of crystal counting.
        @(negedge clk);
        cfg_src = 3'd2; prim_xtal = 1'b1; mon_cfg = 1'b0; pup_sel = 2'd0;
        pulse(1);
        n = 0;
        while (seq_state != 3'd3 && n < 200) begin @(negedge clk); n++; end
        repeat (10) @(negedge clk);
        pulse(8);
        chk("R9 restart stage", int'(seq_state), 0);
        chk("R9 restart core_rst", int'(core_rst), 1);
        chk("R9 restart clk_rdy", int'(clk_rdy), 0);
        observe(1'b0, 1045, 17, 7'h4F, 3'd2);

        // R9: restart from run with the monitor enabled.
        run_seq(3'd0, 1'b0, 1'b1, 2'd0, 1, 21, 17, 7'h67, 3'd0);
        pulse(4);
        chk("R9 restart clears mon_en", int'(mon_en), 0);
        chk("R9 restart clears clk_rdy", int'(clk_rdy), 0);
        chk("R9 restart core_rst", int'(core_rst), 1);
        observe(1'b1, 21, 17, 7'h67, 3'd0);

        // R5: crystal count stalls without ticks, then needs exactly 1024 ticks.
        @(negedge clk);
        osc_tick = 1'b0; cfg_src = 3'd4; prim_xtal = 1'b0; mon_cfg = 1'b0; pup_sel = 2'd0;
        pulse(1);
        n = 0;
        while (seq_state != 3'd3 && n < 200) begin @(negedge clk); n++; end
        repeat (300) @(negedge clk);
        chk("R5 stalls without osc ticks", int'(seq_state), 3);
        osc_tick = 1'b1;
        n = 0;
        while (seq_state == 3'd3 && n < 3000) begin @(negedge clk); n++; end
        chk("R5 tick count", n, 1024);
        chk("R5 run after count", int'(seq_state), 6);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure and still reports.
    initial begin
        #950000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule